// File: doc/BRIEF.md
# Mode-Steered GPIO Port with Upper-Address Muxing

This block is an 8-pin bidirectional port. Each pin either works as general-purpose I/O or carries one of the upper external address bits (bits 16 to 23) from the bus controller. The choice is made per pin, combinationally, from four inputs in fixed priority: the chip's operating mode, an expansion-enable input, the pin's address-enable bit and the pin's direction bit. Software sees three registers on a small register bus:

- a write-only direction register;
- a read/write output-data register;
- a read-only pin register.

The block does not model pads, pull-ups or open-drain drivers. It produces, for every pin, an output value, an output enable and a sampled input level. An integrator connects those signals to the pad ring. The operating mode and the enables come from the system controller and may change at any time. The pin functions follow them in the same cycle.

Top module: `gpio_addr_port`

## Requirements
- R1: After synchronous reset, the direction and data registers both hold 0. With any mode other than 1 or 2, every `pad_oe` is 0 and every `pad_out` is 0.
- R2: Register offset 0 (`bus_addr`=0) is the direction register, one bit per pin, where 1 means output. A write takes effect at the next rising clock edge. A read returns 8'h00.
- R3: Register offset 1 is the output-data register. It is read/write, and a write is visible at the next clock edge. Offset 3 reads 8'h00, and a write to it has no effect.
- R4: In `op_mode` 1 or 2, pins 0 to 4 drive `addr_hi[i]` with `pad_oe[i]`=1, whatever the direction and address-enable bits hold.
- R5: In `op_mode` 1 or 2, a pin i in 5..7 whose `addr_en[i]` is 1 drives `addr_hi[i]` with output enabled when its direction bit is 1. When its direction bit is 0 it is an input (`pad_oe`=0, `pad_out`=0).
- R6: In `op_mode` 1 or 2, a pin i in 5..7 whose `addr_en[i]` is 0 drives data-register bit i with output enabled when its direction bit is 1. When its direction bit is 0 it is an input.
- R7: In `op_mode` 4, and in `op_mode` 7 with `exp_en`=1, every pin follows the address-enable rule. With `addr_en[i]`=1, the direction bit chooses between address output and input. With `addr_en[i]`=0, it chooses between data output and input.
- R8: In `op_mode` 7 with `exp_en`=0, every pin is plain I/O. Direction bit 1 drives data-register bit i, direction bit 0 makes the pin an input, and `addr_en` has no effect.
- R9: `op_mode` values 0, 3, 5 and 6 behave exactly like R8, whatever `exp_en` and `addr_en` hold.
- R10: Register offset 2 reads, per pin, the data-register bit when the pin drives port data. Otherwise it reads the pin level `pad_in` as registered at the previous rising clock edge, so a change on `pad_in` appears one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset (0 direction, 1 data, 2 pin) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_sel` is high and `bus_wr` is low |
| op_mode | input | 3 | Operating mode of the chip |
| exp_en | input | 1 | External expansion enable (used in mode 7) |
| addr_en | input | 8 | Per-pin address-enable bits (bit i for address bit 16+i) |
| addr_hi | input | 8 | Address bits 23..16 from the bus controller |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Value driven on each pin |
| pad_oe | output | 8 | Output enable for each pin |

## Verification
The pin-function mux is tried in every mode class (narrow expansion, wide expansion, expansion off and unlisted codes) under these patterns:

| Pattern | What it separates |
|---------|-------------------|
| Direction 8'h00 / 8'hFF, address-enable 8'h00 / 8'hFF | Address output from data output, and both from input |
| Alternating direction and address-enable patterns | Bit-position slips in the per-pin decode |
| Different values on `addr_hi` and the data register | Which source feeds `pad_out` |
| Non-zero `addr_en` and `exp_en` in modes where they must not matter | Leaks of the enables into plain-I/O modes |

Pin register reads mix data-driven pins with input and address pins, and are taken before and after a sampling edge. This separates the data-register path from the registered pad path and confirms the one-edge latency.

// File: rtl/gap_pkg.sv
package gap_pkg;

    localparam int PORT_W          = 8;
    localparam int NARROW_FIXED    = 5;
    localparam int REG_ADDR_W      = 2;

    typedef enum logic [1:0] {
        PF_INPUT = 2'd0,
        PF_DATA  = 2'd1,
        PF_ADDR  = 2'd2
    } pin_fn_e;

    typedef enum logic [1:0] {
        MAP_PLAIN  = 2'd0,
        MAP_NARROW = 2'd1,
        MAP_WIDE   = 2'd2
    } port_map_e;

    typedef enum logic [1:0] {
        RA_DIR  = 2'd0,
        RA_DATA = 2'd1,
        RA_PIN  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    // Mode class: narrow expansion, wide expansion, or plain I/O fallback.
    function automatic port_map_e mode_class(logic [2:0] mode, logic exp);
        port_map_e m;
        case (mode)
            3'd1, 3'd2: m = MAP_NARROW;
            3'd4:       m = MAP_WIDE;
            3'd7:       m = exp ? MAP_WIDE : MAP_PLAIN;
            default:    m = MAP_PLAIN;
        endcase
        return m;
    endfunction

    // Priority: fixed address pin, then address-enable, then direction.
    function automatic pin_fn_e pin_select(port_map_e m, logic fixed_pin,
                                           logic aen, logic dir);
        pin_fn_e f;
        if (m == MAP_NARROW && fixed_pin)
            f = PF_ADDR;
        else if (m != MAP_PLAIN && aen)
            f = dir ? PF_ADDR : PF_INPUT;
        else
            f = dir ? PF_DATA : PF_INPUT;
        return f;
    endfunction

endpackage

// File: rtl/gap_regs.sv
module gap_regs
    import gap_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_dir,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_dir)
                dir_q <= wdata;
            if (wr_data)
                data_q <= wdata;
        end
    end

endmodule

// File: rtl/gap_pin_func.sv
module gap_pin_func
    import gap_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int FIXED = NARROW_FIXED
) (
    input  logic [2:0]          op_mode,
    input  logic                exp_en,
    input  logic [W-1:0]        addr_en,
    input  logic [W-1:0]        dir_q,
    output pin_fn_e [W-1:0]     fn_o
);

    port_map_e map_c;

    always_comb map_c = mode_class(op_mode, exp_en);

    for (genvar i = 0; i < W; i++) begin : g_pin
        localparam logic IS_FIXED = (i < FIXED);
        always_comb fn_o[i] = pin_select(map_c, IS_FIXED, addr_en[i], dir_q[i]);
    end

endmodule

// File: rtl/gap_pin_drive.sv
module gap_pin_drive
    import gap_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  pin_fn_e [W-1:0] fn_i,
    input  logic [W-1:0]    data_q,
    input  logic [W-1:0]    addr_hi,
    input  logic [W-1:0]    pad_in,
    output logic [W-1:0]    pad_out,
    output logic [W-1:0]    pad_oe,
    output logic [W-1:0]    pin_rb
);

    logic [W-1:0] pad_smp_q;
    pin_drive_t   drv [W];

    always_ff @(posedge clk) begin
        if (rst)
            pad_smp_q <= '0;
        else
            pad_smp_q <= pad_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_drv
        always_comb begin
            unique case (fn_i[i])
                PF_ADDR: drv[i] = '{oe: 1'b1, val: addr_hi[i]};
                PF_DATA: drv[i] = '{oe: 1'b1, val: data_q[i]};
                default: drv[i] = '{oe: 1'b0, val: 1'b0};
            endcase
        end
        assign pad_oe[i]  = drv[i].oe;
        assign pad_out[i] = drv[i].val;
        assign pin_rb[i]  = (fn_i[i] == PF_DATA) ? data_q[i] : pad_smp_q[i];
    end

endmodule

// File: rtl/gpio_addr_port.sv
module gpio_addr_port
    import gap_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int FIXED = NARROW_FIXED
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          bus_rdata,
    input  logic [2:0]            op_mode,
    input  logic                  exp_en,
    input  logic [W-1:0]          addr_en,
    input  logic [W-1:0]          addr_hi,
    input  logic [W-1:0]          pad_in,
    output logic [W-1:0]          pad_out,
    output logic [W-1:0]          pad_oe
);

    reg_addr_e       ra;
    logic            wr_dir, wr_data, rd_en;
    logic [W-1:0]    dir_q, data_q, pin_rb;
    pin_fn_e [W-1:0] fn;

    assign ra      = reg_addr_e'(bus_addr);
    assign wr_dir  = bus_sel && bus_wr && (ra == RA_DIR);
    assign wr_data = bus_sel && bus_wr && (ra == RA_DATA);
    assign rd_en   = bus_sel && !bus_wr;

    gap_regs #(.W(W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_dir  (wr_dir),
        .wr_data (wr_data),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    gap_pin_func #(.W(W), .FIXED(FIXED)) func_i (
        .op_mode (op_mode),
        .exp_en  (exp_en),
        .addr_en (addr_en),
        .dir_q   (dir_q),
        .fn_o    (fn)
    );

    gap_pin_drive #(.W(W)) drive_i (
        .clk     (clk),
        .rst     (rst),
        .fn_i    (fn),
        .data_q  (data_q),
        .addr_hi (addr_hi),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pin_rb  (pin_rb)
    );

    // Direction register is write-only: it reads as zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (ra)
                RA_DATA: bus_rdata = data_q;
                RA_PIN:  bus_rdata = pin_rb;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gap_port_chk.sv
module gap_port_chk #(
    parameter int W     = 8,
    parameter int FIXED = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [2:0]   op_mode,
    input logic         exp_en,
    input logic [W-1:0] addr_hi,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] data_q
);

    logic narrow;
    assign narrow = (op_mode == 3'd1) || (op_mode == 3'd2);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !narrow) |-> (pad_oe == '0 && pad_out == '0));

    p_dir_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 2'd0) |-> (bus_rdata == '0));

    p_data_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> (data_q == $past(bus_wdata)));

    p_fixed_addr_pins_r4: assert property (@(posedge clk) disable iff (rst)
        narrow |-> (pad_oe[FIXED-1:0] == '1 &&
                    pad_out[FIXED-1:0] == addr_hi[FIXED-1:0]));

    p_oe_needs_dir_r7: assert property (@(posedge clk) disable iff (rst)
        !narrow |-> ((pad_oe & ~dir_q) == '0));

    p_plain_follows_dir_r8: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 3'd7 && !exp_en) |-> (pad_oe == dir_q &&
                                          pad_out == (dir_q & data_q)));

endmodule

bind gpio_addr_port gap_port_chk #(.W(W), .FIXED(FIXED)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .op_mode   (op_mode),
    .exp_en    (exp_en),
    .addr_hi   (addr_hi),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .dir_q     (dir_q),
    .data_q    (data_q)
);

// File: tb/gpio_addr_port_tb_top.sv
module gpio_addr_port_tb_top;

    logic       clk = 0;
    logic       rst = 1;
    logic       bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [2:0] op_mode = 3'd7;
    logic       exp_en = 0;
    logic [7:0] addr_en = 0, addr_hi = 0, pad_in = 0, pad_out, pad_oe;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] sh_dir = 0, sh_data = 0;

    always #5 clk = ~clk;

    gpio_addr_port dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .op_mode(op_mode), .exp_en(exp_en), .addr_en(addr_en),
        .addr_hi(addr_hi), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected pin function: 0 input, 1 data, 2 address.
    function automatic int exp_fn(int i);
        bit nar = (op_mode == 3'd1 || op_mode == 3'd2);
        bit wid = (op_mode == 3'd4) || (op_mode == 3'd7 && exp_en);
        if (nar && i < 5) return 2;
        if ((nar || wid) && addr_en[i]) return sh_dir[i] ? 2 : 0;
        return sh_dir[i] ? 1 : 0;
    endfunction

    function automatic logic [15:0] exp_pins();
        logic [7:0] oe = 0, ov = 0;
        for (int i = 0; i < 8; i++) begin
            case (exp_fn(i))
                2: begin oe[i] = 1; ov[i] = addr_hi[i]; end
                1: begin oe[i] = 1; ov[i] = sh_data[i]; end
                default: ;
            endcase
        end
        return {oe, ov};
    endfunction

    task automatic reg_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (a == 2'd0) sh_dir = d;
        if (a == 2'd1) sh_data = d;
    endtask

    task automatic reg_rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic set_pins(logic [2:0] m, logic e, logic [7:0] aen, logic [7:0] a);
        @(negedge clk);
        op_mode = m; exp_en = e; addr_en = aen; addr_hi = a;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        set_pins(3'd7, 0, 8'hFF, 8'hFF);
        check("R1 pins after reset", {pad_oe, pad_out}, 16'h0000);
        reg_rd(2'd1, d);
        check("R1 data reg after reset", {8'h0, d}, 16'h0000);
        set_pins(3'd4, 1, 8'hFF, 8'hFF);
        check("R1 mode4 after reset", {pad_oe, pad_out}, 16'h0000);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        reg_wr(2'd1, 8'hA5);
        reg_rd(2'd1, d);
        check("R3 data readback", {8'h0, d}, 16'h00A5);
        reg_wr(2'd0, 8'h3C);
        reg_rd(2'd0, d);
        check("R2 direction reads zero", {8'h0, d}, 16'h0000);
        set_pins(3'd7, 0, 8'h00, 8'h00);
        check("R2 direction takes effect", {pad_oe, pad_out}, {8'h3C, 8'h24});
        reg_wr(2'd3, 8'hFF);
        reg_rd(2'd3, d);
        check("R3 offset3 reads zero", {8'h0, d}, 16'h0000);
        reg_rd(2'd1, d);
        check("R3 offset3 write ignored", {8'h0, d}, 16'h00A5);
    endtask

    task automatic t_narrow();
        logic [7:0] dirs [3] = '{8'h00, 8'hFF, 8'hA0};
        reg_wr(2'd1, 8'h3C);
        for (int m = 1; m <= 2; m++) begin
            for (int k = 0; k < 3; k++) begin
                reg_wr(2'd0, dirs[k]);
                set_pins(3'(m), 0, 8'h00, 8'h5A);
                check("R4 low pins address", {3'b0, pad_oe[4:0], 3'b0, pad_out[4:0]},
                      {3'b0, 5'h1F, 3'b0, 5'h1A});
                check("R6 upper pins no enable", {pad_oe, pad_out}, exp_pins());
                set_pins(3'(m), 1, 8'hE0, 8'hA5);
                check("R5 upper pins enabled", {pad_oe, pad_out}, exp_pins());
                set_pins(3'(m), 0, 8'h40, 8'hC3);
                check("R5 R6 mixed enables", {pad_oe, pad_out}, exp_pins());
            end
        end
    endtask

    task automatic t_wide();
        logic [7:0] aens [3] = '{8'hFF, 8'h0F, 8'h00};
        logic [7:0] dirs [2] = '{8'hFF, 8'h33};
        reg_wr(2'd1, 8'h96);
        for (int d = 0; d < 2; d++) begin
            reg_wr(2'd0, dirs[d]);
            for (int k = 0; k < 3; k++) begin
                set_pins(3'd4, 0, aens[k], 8'h5A);
                check("R7 mode4", {pad_oe, pad_out}, exp_pins());
                set_pins(3'd7, 1, aens[k], 8'hC3);
                check("R7 mode7 expanded", {pad_oe, pad_out}, exp_pins());
            end
        end
    endtask

    task automatic t_plain();
        reg_wr(2'd0, 8'h69);
        reg_wr(2'd1, 8'hF0);
        set_pins(3'd7, 0, 8'hFF, 8'hFF);
        check("R8 plain io enables ignored", {pad_oe, pad_out}, {8'h69, 8'h60});
        set_pins(3'd7, 0, 8'h00, 8'h00);
        check("R8 plain io", {pad_oe, pad_out}, {8'h69, 8'h60});
    endtask

    task automatic t_unlisted();
        logic [2:0] ms [4] = '{3'd0, 3'd3, 3'd5, 3'd6};
        for (int k = 0; k < 4; k++) begin
            set_pins(ms[k], 1, 8'hFF, 8'hFF);
            check("R9 unlisted mode", {pad_oe, pad_out}, {8'h69, 8'h60});
        end
    endtask

    task automatic t_pin_read();
        logic [7:0] d;
        reg_wr(2'd0, 8'h0F);
        reg_wr(2'd1, 8'h55);
        set_pins(3'd7, 0, 8'h00, 8'h00);
        pad_in = 8'hC3;
        @(negedge clk);
        reg_rd(2'd2, d);
        check("R10 pin read plain", {8'h0, d}, 16'h00C5);
        @(negedge clk);
        pad_in = 8'h3C;
        #1 bus_sel = 1; bus_wr = 0; bus_addr = 2'd2;
        #1 d = bus_rdata;
        bus_sel = 0;
        check("R10 pin read before sampling edge", {8'h0, d}, 16'h00C5);
        reg_rd(2'd2, d);
        check("R10 pin read after sampling edge", {8'h0, d}, 16'h0035);
        reg_wr(2'd0, 8'hFF);
        set_pins(3'd4, 0, 8'hF0, 8'h00);
        pad_in = 8'hA0;
        @(negedge clk);
        reg_rd(2'd2, d);
        check("R10 pin read address pins", {8'h0, d}, 16'h00A5);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_regs();
        t_narrow();
        t_wide();
        t_plain();
        t_unlisted();
        t_pin_read();
        finish_run();
    end

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule